// File: doc/BRIEF.md
# Dual-Port Hardware Lock Bank

This block holds a set of single-bit mutual-exclusion flags that two processor ports share. Each port drives a word address, a read strobe and a write strobe, and gets back registered read data. A read of a lock address is an atomic test-and-set. If the lock was free, the read claims it and returns a one-hot word with the bit for that lock set. If the lock was already held, the read returns zero and changes nothing. A write strobe to a lock address frees that lock. No data is carried on a write, so the written value has no meaning.

Software uses the bank as follows. It reads a lock address until the result is nonzero. It then runs its critical section and writes the same address to give the lock up. When both ports contend for the same free lock in one cycle, port 0 takes it. A status vector shows which locks are held at any time, and observing it has no side effect.

Top module: `hw_lock_bank`

## Requirements
- R1: The locks sit in a window of word addresses starting at byte address 0x100. Lock i is at 0x100 + 4*i for i = 0..31, and address bits [1:0] are ignored. A strobe to an address outside 0x100..0x17F has no effect: a read returns 0 and a write changes no lock.
- R2: A read of a lock that is held returns 0 and leaves every lock unchanged.
- R3: A read of a free lock returns 1 << i on its port's read data one cycle after the strobe. On the same clock edge, bit i of `held_o` becomes 1.
- R4: A write strobe from either port to lock i clears bit i of `held_o` on the next edge, whether or not the lock was held.
- R5: If both ports read the same free lock in one cycle, port 0 receives the one-hot value, port 1 receives 0, and the lock becomes held.
- R6: If both ports read two different free locks in one cycle, both claims succeed independently.
- R7: If a lock is written by either port in the same cycle that it is read, the read returns 0 and the lock ends up free.
- R8: While reset is high, every lock is freed and both read data outputs are 0. A read strobe during reset claims nothing.
- R9: In a cycle without a read strobe, that port's read data is 0 in the following cycle. Observing `held_o` never changes the lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_addr | input | 12 | Port 0 byte address |
| p0_rd | input | 1 | Port 0 read strobe (test-and-set) |
| p0_wr | input | 1 | Port 0 write strobe (release) |
| p0_rdata | output | 32 | Port 0 registered read result |
| p1_addr | input | 12 | Port 1 byte address |
| p1_rd | input | 1 | Port 1 read strobe (test-and-set) |
| p1_wr | input | 1 | Port 1 write strobe (release) |
| p1_rdata | output | 32 | Port 1 registered read result |
| held_o | output | 32 | One bit per lock, 1 = held |

## Verification
The directed patterns each isolate one behaviour:
- a single-port claim followed by a re-read from the other port separates success from failure;
- both ports reading one lock exposes the port-0 priority;
- both ports reading different locks shows that claims are independent;
- a write and a read aimed at the same lock in one cycle shows that the release wins;
- addresses just outside the window, and addresses with low byte bits set, show the decode edges.

Random traffic then mixes claims, releases and misses on both ports, with frequent collisions, against a reference model of the lock array. This separates a correct design from one with a wrong grant rule or a missing release.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

    localparam int unsigned LOCK_N    = 32;
    localparam int unsigned IDX_W     = $clog2(LOCK_N);
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned WORD_LSB  = 2;
    localparam int unsigned TAG_LSB   = IDX_W + WORD_LSB;
    localparam int unsigned NUM_PORTS = 2;
    localparam logic [ADDR_W-1:0] WIN_BASE = 12'h100;

    typedef logic [LOCK_N-1:0] lock_vec_t;
    typedef logic [IDX_W-1:0]  lock_idx_t;

    typedef struct packed {
        lock_vec_t claim;
        lock_vec_t drop;
    } port_req_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:TAG_LSB] == WIN_BASE[ADDR_W-1:TAG_LSB];
    endfunction

    function automatic lock_idx_t addr_to_idx(input logic [ADDR_W-1:0] a);
        return a[TAG_LSB-1:WORD_LSB];
    endfunction

    function automatic lock_vec_t idx_onehot(input lock_idx_t i);
        return lock_vec_t'(1) << i;
    endfunction

endpackage

// File: rtl/hwlock_port_dec.sv
module hwlock_port_dec
    import hwlock_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output port_req_t         req
);
    logic      hit;
    lock_vec_t sel;

    always_comb begin
        hit       = in_window(addr);
        sel       = idx_onehot(addr_to_idx(addr));
        req.claim = (rd && hit) ? sel : '0;
        req.drop  = (wr && hit) ? sel : '0;
    end
endmodule

// File: rtl/hwlock_arb.sv
module hwlock_arb
    import hwlock_pkg::*;
(
    input  lock_vec_t held,
    input  port_req_t req0,
    input  port_req_t req1,
    output lock_vec_t grant0,
    output lock_vec_t grant1,
    output lock_vec_t held_next
);
    lock_vec_t drop_any;
    lock_vec_t avail;

    always_comb begin
        drop_any  = req0.drop | req1.drop;
        avail     = ~held & ~drop_any;
        grant0    = req0.claim & avail;
        grant1    = req1.claim & avail & ~req0.claim;
        held_next = (held | grant0 | grant1) & ~drop_any;
    end
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
    import hwlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic              p0_rd,
    input  logic              p0_wr,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic              p1_rd,
    input  logic              p1_wr,
    output logic [DATA_W-1:0] p1_rdata,
    output logic [LOCK_N-1:0] held_o
);
    logic [ADDR_W-1:0] addr_a [NUM_PORTS];
    logic              rd_a   [NUM_PORTS];
    logic              wr_a   [NUM_PORTS];
    port_req_t         req_a  [NUM_PORTS];
    lock_vec_t         grant_a[NUM_PORTS];
    logic [DATA_W-1:0] rdat_q [NUM_PORTS];
    lock_vec_t         held_q;
    lock_vec_t         held_d;

    always_comb begin
        addr_a[0] = p0_addr; rd_a[0] = p0_rd; wr_a[0] = p0_wr;
        addr_a[1] = p1_addr; rd_a[1] = p1_rd; wr_a[1] = p1_wr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        hwlock_port_dec u_dec (
            .addr (addr_a[p]),
            .rd   (rd_a[p]),
            .wr   (wr_a[p]),
            .req  (req_a[p])
        );

        always_ff @(posedge clk) begin
            if (rst) rdat_q[p] <= '0;
            else     rdat_q[p] <= DATA_W'(grant_a[p]);
        end
    end

    hwlock_arb u_arb (
        .held      (held_q),
        .req0      (req_a[0]),
        .req1      (req_a[1]),
        .grant0    (grant_a[0]),
        .grant1    (grant_a[1]),
        .held_next (held_d)
    );

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= held_d;
    end

    assign p0_rdata = rdat_q[0];
    assign p1_rdata = rdat_q[1];
    assign held_o   = held_q;
endmodule

// File: rtl/hwlock_checker.sv
module hwlock_checker
    import hwlock_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] p0_addr,
    input logic              p0_rd,
    input logic              p0_wr,
    input logic [DATA_W-1:0] p0_rdata,
    input logic [ADDR_W-1:0] p1_addr,
    input logic              p1_rd,
    input logic              p1_wr,
    input logic [DATA_W-1:0] p1_rdata,
    input logic [LOCK_N-1:0] held_o
);
    logic      rst_q = 1'b0;
    logic      hit0, hit1;
    lock_idx_t idx0, idx1;

    always_ff @(posedge clk) rst_q <= rst;

    always_comb begin
        hit0 = in_window(p0_addr);
        hit1 = in_window(p1_addr);
        idx0 = addr_to_idx(p0_addr);
        idx1 = addr_to_idx(p1_addr);
    end

    AST_RESET_FREE: assert property (@(posedge clk)
        (rst_q && !rst) |-> (held_o == '0 && p0_rdata == '0 && p1_rdata == '0)); // R8

    AST_RDATA_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(p0_rdata) && $onehot0(p1_rdata)); // R3

    AST_HELD_READ_ZERO_P0: assert property (@(posedge clk) disable iff (rst)
        (p0_rd && hit0 && held_o[idx0]) |=> p0_rdata == '0); // R2

    AST_HELD_READ_ZERO_P1: assert property (@(posedge clk) disable iff (rst)
        (p1_rd && hit1 && held_o[idx1]) |=> p1_rdata == '0); // R2

    AST_TIE_PORT0_WINS: assert property (@(posedge clk) disable iff (rst)
        (p0_rd && p1_rd && hit0 && hit1 && idx0 == idx1 && !held_o[idx0] && !p0_wr && !p1_wr)
        |=> (p1_rdata == '0 && p0_rdata != '0)); // R5

    AST_RELEASE_P0: assert property (@(posedge clk) disable iff (rst)
        (p0_wr && hit0) |=> !held_o[$past(idx0)]); // R4

    AST_RELEASE_P1: assert property (@(posedge clk) disable iff (rst)
        (p1_wr && hit1) |=> !held_o[$past(idx1)]); // R4

    AST_DROP_BEATS_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (p1_wr && hit1 && p0_rd && hit0 && idx0 == idx1) |=> p0_rdata == '0); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!p0_rd && !p1_rd) |=> (p0_rdata == '0 && p1_rdata == '0)); // R9
endmodule

bind hw_lock_bank hwlock_checker u_chk (.*);

// File: tb/tb_hw_lock_bank.sv
module tb_hw_lock_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] p0_addr = '0, p1_addr = '0;
    logic        p0_rd = 0, p0_wr = 0, p1_rd = 0, p1_wr = 0;
    logic [31:0] p0_rdata, p1_rdata, held_o;

    int unsigned n_chk = 0, n_err = 0;
    logic [31:0] m_held = '0;
    bit          done = 0;

    always #5 clk = ~clk;

    hw_lock_bank dut (.*);

    function automatic bit f_hit(input logic [11:0] a);
        return a >= 12'h100 && a <= 12'h17F;
    endfunction

    function automatic int f_idx(input logic [11:0] a);
        return int'((a - 12'h100) >> 2);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [11:0] a0, input bit r0, input bit w0,
                        input logic [11:0] a1, input bit r1, input bit w1,
                        input string tag);
        logic [31:0] e0, e1, rel;
        bit c0, c1;
        int i0, i1;
        i0 = f_idx(a0); i1 = f_idx(a1);
        c0 = r0 && f_hit(a0); c1 = r1 && f_hit(a1);
        rel = '0;
        if (w0 && f_hit(a0)) rel[i0] = 1'b1;
        if (w1 && f_hit(a1)) rel[i1] = 1'b1;
        e0 = '0; e1 = '0;
        if (c0 && !m_held[i0] && !rel[i0]) e0 = 32'd1 << i0;
        if (c1 && !m_held[i1] && !rel[i1] && !(c0 && i0 == i1)) e1 = 32'd1 << i1;
        m_held = (m_held | e0 | e1) & ~rel;
        @(negedge clk);
        p0_addr = a0; p0_rd = r0; p0_wr = w0;
        p1_addr = a1; p1_rd = r1; p1_wr = w1;
        @(posedge clk); #1;
        check({tag, " p0_rdata"}, p0_rdata, e0);
        check({tag, " p1_rdata"}, p1_rdata, e1);
        check({tag, " held_o"}, held_o, m_held);
    endtask

    function automatic logic [11:0] rnd_addr();
        if ($urandom_range(9) == 0) return 12'($urandom);
        return 12'h100 + 12'(4 * $urandom_range(31)) + 12'($urandom_range(3));
    endfunction

    initial begin
        void'($urandom(32'd2024));
        // R8: reads during reset claim nothing
        p0_addr = 12'h100; p0_rd = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0; p0_rd = 0;
        check("R8 held after reset", held_o, '0);
        check("R8 p0_rdata after reset", p0_rdata, '0);
        check("R8 p1_rdata after reset", p1_rdata, '0);

        step(12'h114, 1, 0, 12'h000, 0, 0, "R3 claim lock 5");
        step(12'h000, 0, 0, 12'h114, 1, 0, "R2 reread held lock");
        step(12'h17C, 1, 0, 12'h000, 0, 0, "R3 claim lock 31");
        step(12'h0FC, 1, 1, 12'h180, 1, 1, "R1 outside window");
        step(12'h000, 0, 0, 12'h114, 0, 1, "R4 release by other port");
        step(12'h000, 0, 0, 12'h114, 0, 1, "R4 release of free lock");
        step(12'h120, 1, 0, 12'h120, 1, 0, "R5 same-lock tie");
        step(12'h124, 1, 0, 12'h128, 1, 0, "R6 different locks");
        step(12'h12A, 1, 0, 12'h12A, 0, 1, "R7 release vs claim");
        step(12'h124, 0, 1, 12'h124, 1, 0, "R7 release vs claim p1");
        step(12'h17F, 0, 1, 12'h000, 0, 0, "R1 R4 low bits ignored");
        repeat (3) step(12'h100, 0, 0, 12'h100, 0, 0, "R9 idle");

        for (int k = 0; k < 3000; k++)
            step(rnd_addr(), $urandom_range(1) == 1, $urandom_range(4) == 0,
                 rnd_addr(), $urandom_range(1) == 1, $urandom_range(4) == 0,
                 "random R1/R2/R3/R4/R5/R6/R7/R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule